// File: doc/BRIEF.md
# Fused Multiply-Add Special-Case Resolver

This combinational block sits in front of a binary64 fused multiply-add datapath that evaluates z + x·y. It accepts the three 64-bit operands, two sign controls (one inverts the product sign, one inverts the addend sign) and the rounding-mode field. It sorts each operand into one of six classes: zero, denormal, normal, infinity, quiet NaN or signalling NaN.

From those classes it either produces the final result and raises invalid-operation where needed, or tells the datapath that real arithmetic is required. In the second case it also hands over the effective signs and the per-operand denormal indications. The datapath uses them to normalise its inputs. Significand arithmetic, rounding and the remaining exception flags belong to the datapath.

The resolver has no state. All outputs follow the inputs in the same cycle.

Top module: `fma_special_resolver`

## Requirements
- R1: `denorm_o` bit 2 flags z, bit 1 flags x and bit 0 flags y. A bit is set when its operand has a zero exponent field and a non-zero fraction.
- R2: `prod_sign_o` equals sign(x) XOR sign(y), inverted when `neg_prod_i` is 1. `add_sign_o` equals sign(z), inverted when `neg_add_i` is 1.
- R3: A signalling NaN (exponent all ones, fraction non-zero, fraction bit 51 clear) outranks every other case. The operands are examined in the order z, then x, then y. The first signalling NaN found is returned with fraction bit 51 set, and `invalid_o` is raised.
- R4: When there is no signalling NaN, the first quiet NaN (fraction bit 51 set), examined in the order z, x, y, is returned unchanged. `invalid_o` stays 0.
- R5: An infinity times a zero, in either order, returns 0x7FF8000000000000 and raises `invalid_o`.
- R6: An infinite product with an infinite z of the other effective sign returns 0x7FF8000000000000 with `invalid_o`. Any other infinite product returns an infinity carrying `prod_sign_o`.
- R7: A zero product with infinite z returns an infinity with the effective addend sign. A zero product with finite non-zero z returns z's magnitude with the effective addend sign.
- R8: A zero product with zero z returns a zero. When the effective signs are equal it carries that sign. When they differ, the zero is negative only when `rnd_mode_i` equals 3 (round toward minus infinity).
- R9: A finite non-zero product with infinite z returns an infinity with the effective addend sign.
- R10: `compute_o` is 1 exactly when none of R3 to R9 applies, and `special_o` is its complement. `invalid_o` is never 1 without `special_o`. `result_o` is 0 while `compute_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| z_i | input | 64 | Addend operand |
| x_i | input | 64 | First multiplicand |
| y_i | input | 64 | Second multiplicand |
| neg_prod_i | input | 1 | Invert product sign |
| neg_add_i | input | 1 | Invert addend sign |
| rnd_mode_i | input | 2 | Rounding mode, 3 = toward minus infinity |
| special_o | output | 1 | Final result is on result_o |
| compute_o | output | 1 | Datapath must compute the result |
| invalid_o | output | 1 | Invalid-operation flag |
| result_o | output | 64 | Special result |
| denorm_o | output | 3 | Denormal flags {z, x, y} |
| prod_sign_o | output | 1 | Effective product sign |
| add_sign_o | output | 1 | Effective addend sign |

## Verification
The bench places signalling and quiet NaNs on several operands at once, so a wrong precedence order shows up. It would return the wrong payload, or leave an sNaN payload unquietened. Opposite-signed and same-signed infinity pairs are created with the negate controls, so a resolver that ignored either control would flip between the default NaN and an infinity. Zero-plus-zero cancellation is run under two rounding modes to expose a hard-wired zero sign. Denormal and plain normal operands check that `compute_o` is raised only when no shortcut applies, and that the effective signs and denormal flags reach the datapath.

// File: rtl/fma_sc_pkg.sv
package fma_sc_pkg;
  localparam int EXP_W_DEF  = 11;
  localparam int FRAC_W_DEF = 52;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_DNORM,
    CLS_NORM,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } fp_class_e;

  // operand slot order used for NaN precedence
  localparam int SLOT_Z = 2;
  localparam int SLOT_X = 1;
  localparam int SLOT_Y = 0;
endpackage

// File: rtl/fma_sc_classify.sv
module fma_sc_classify
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = EXP_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF,
  localparam int W     = EXP_W + FRAC_W + 1
) (
  input  logic [W-1:0] op_i,
  output fp_class_e    class_o,
  output logic         sign_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max, exp_min, frac_nz;

  assign exp_f   = op_i[W-2 -: EXP_W];
  assign frac_f  = op_i[FRAC_W-1:0];
  assign sign_o  = op_i[W-1];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    if (exp_max) begin
      if (!frac_nz)                class_o = CLS_INF;
      else if (frac_f[FRAC_W-1])   class_o = CLS_QNAN;
      else                         class_o = CLS_SNAN;
    end else if (exp_min) begin
      class_o = frac_nz ? CLS_DNORM : CLS_ZERO;
    end else begin
      class_o = CLS_NORM;
    end
  end
endmodule

// File: rtl/fma_sc_nan_pick.sv
module fma_sc_nan_pick
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = EXP_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF,
  localparam int W     = EXP_W + FRAC_W + 1
) (
  input  logic [2:0][W-1:0] ops_i,
  input  fp_class_e [2:0]   cls_i,
  output logic              hit_o,
  output logic              inv_o,
  output logic [W-1:0]      val_o
);
  localparam logic [W-1:0] QUIET_BIT = W'(1) << (FRAC_W - 1);

  always_comb begin
    hit_o = 1'b0;
    inv_o = 1'b0;
    val_o = '0;
    // slot 2 (z) first, then x, then y; signalling before quiet
    for (int i = 2; i >= 0; i--) begin
      if (!hit_o && cls_i[i] == CLS_SNAN) begin
        hit_o = 1'b1;
        inv_o = 1'b1;
        val_o = ops_i[i] | QUIET_BIT;
      end
    end
    for (int i = 2; i >= 0; i--) begin
      if (!hit_o && cls_i[i] == CLS_QNAN) begin
        hit_o = 1'b1;
        val_o = ops_i[i];
      end
    end
  end

  always_comb begin
    if (!$isunknown(ops_i)) begin
      // R3
      snan_quiet_chk: assert (!inv_o || val_o[FRAC_W-1]);
    end
  end
endmodule

// File: rtl/fma_sc_arith_cases.sv
module fma_sc_arith_cases
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = EXP_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF,
  parameter int RM_W   = 2,
  parameter logic [RM_W-1:0] RM_DOWN = RM_W'(3),
  localparam int W     = EXP_W + FRAC_W + 1
) (
  input  fp_class_e        cls_z_i,
  input  fp_class_e        cls_x_i,
  input  fp_class_e        cls_y_i,
  input  logic [W-2:0]     z_mag_i,
  input  logic             prod_sign_i,
  input  logic             add_sign_i,
  input  logic [RM_W-1:0]  rnd_mode_i,
  output logic             hit_o,
  output logic             inv_o,
  output logic [W-1:0]     val_o
);
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic x_inf, y_inf, x_zero, y_zero, z_inf, z_zero;
  logic inf_times_zero, prod_inf, prod_zero;

  assign x_inf  = (cls_x_i == CLS_INF);
  assign y_inf  = (cls_y_i == CLS_INF);
  assign z_inf  = (cls_z_i == CLS_INF);
  assign x_zero = (cls_x_i == CLS_ZERO);
  assign y_zero = (cls_y_i == CLS_ZERO);
  assign z_zero = (cls_z_i == CLS_ZERO);

  assign inf_times_zero = (x_inf && y_zero) || (x_zero && y_inf);
  assign prod_inf       = (x_inf || y_inf) && !(x_zero || y_zero);
  assign prod_zero      = (x_zero || y_zero) && !(x_inf || y_inf);

  always_comb begin
    hit_o = 1'b1;
    inv_o = 1'b0;
    val_o = '0;
    if (inf_times_zero) begin
      inv_o = 1'b1;
      val_o = DEF_NAN;
    end else if (prod_inf) begin
      if (z_inf && (add_sign_i != prod_sign_i)) begin
        inv_o = 1'b1;
        val_o = DEF_NAN;
      end else begin
        val_o = {prod_sign_i, INF_MAG};
      end
    end else if (prod_zero) begin
      if (z_inf)
        val_o = {add_sign_i, INF_MAG};
      else if (z_zero)
        val_o = (add_sign_i == prod_sign_i) ? {add_sign_i, {(W-1){1'b0}}}
                                            : {(rnd_mode_i == RM_DOWN), {(W-1){1'b0}}};
      else
        val_o = {add_sign_i, z_mag_i};
    end else if (z_inf) begin
      val_o = {add_sign_i, INF_MAG};
    end else begin
      hit_o = 1'b0;
    end
  end

  always_comb begin
    if (!$isunknown({cls_x_i, cls_y_i})) begin
      // R5
      inf_zero_inv_chk: assert (!inf_times_zero || (inv_o && val_o == DEF_NAN));
    end
  end
endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = EXP_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF,
  parameter int RM_W   = 2,
  parameter logic [RM_W-1:0] RM_DOWN = RM_W'(3),
  localparam int W     = EXP_W + FRAC_W + 1
) (
  input  logic [W-1:0]    z_i,
  input  logic [W-1:0]    x_i,
  input  logic [W-1:0]    y_i,
  input  logic            neg_prod_i,
  input  logic            neg_add_i,
  input  logic [RM_W-1:0] rnd_mode_i,
  output logic            special_o,
  output logic            compute_o,
  output logic            invalid_o,
  output logic [W-1:0]    result_o,
  output logic [2:0]      denorm_o,
  output logic            prod_sign_o,
  output logic            add_sign_o
);
  logic [2:0][W-1:0] ops;
  fp_class_e [2:0]   cls;
  logic [2:0]        sgn;

  assign ops[SLOT_Z] = z_i;
  assign ops[SLOT_X] = x_i;
  assign ops[SLOT_Y] = y_i;

  for (genvar g = 0; g < 3; g++) begin : g_cls
    fma_sc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op_i    (ops[g]),
      .class_o (cls[g]),
      .sign_o  (sgn[g])
    );
    assign denorm_o[g] = (cls[g] == CLS_DNORM);
  end

  assign prod_sign_o = sgn[SLOT_X] ^ sgn[SLOT_Y] ^ neg_prod_i;
  assign add_sign_o  = sgn[SLOT_Z] ^ neg_add_i;

  logic         nan_hit, nan_inv;
  logic [W-1:0] nan_val;
  logic         ar_hit, ar_inv;
  logic [W-1:0] ar_val;

  fma_sc_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan (
    .ops_i (ops),
    .cls_i (cls),
    .hit_o (nan_hit),
    .inv_o (nan_inv),
    .val_o (nan_val)
  );

  fma_sc_arith_cases #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .RM_W(RM_W), .RM_DOWN(RM_DOWN)) u_ar (
    .cls_z_i     (cls[SLOT_Z]),
    .cls_x_i     (cls[SLOT_X]),
    .cls_y_i     (cls[SLOT_Y]),
    .z_mag_i     (z_i[W-2:0]),
    .prod_sign_i (prod_sign_o),
    .add_sign_i  (add_sign_o),
    .rnd_mode_i  (rnd_mode_i),
    .hit_o       (ar_hit),
    .inv_o       (ar_inv),
    .val_o       (ar_val)
  );

  always_comb begin
    special_o = nan_hit || ar_hit;
    compute_o = !special_o;
    invalid_o = nan_hit ? nan_inv : ar_inv;
    result_o  = nan_hit ? nan_val : (ar_hit ? ar_val : '0);
  end

  logic any_snan, any_qnan, any_inf, xy_zero;
  assign any_snan = (z_i[W-2 -: EXP_W] == '1 && z_i[FRAC_W-1:0] != '0 && !z_i[FRAC_W-1])
                 || (x_i[W-2 -: EXP_W] == '1 && x_i[FRAC_W-1:0] != '0 && !x_i[FRAC_W-1])
                 || (y_i[W-2 -: EXP_W] == '1 && y_i[FRAC_W-1:0] != '0 && !y_i[FRAC_W-1]);
  assign any_qnan = (z_i[W-2 -: EXP_W] == '1 && z_i[FRAC_W-1])
                 || (x_i[W-2 -: EXP_W] == '1 && x_i[FRAC_W-1])
                 || (y_i[W-2 -: EXP_W] == '1 && y_i[FRAC_W-1]);
  assign any_inf  = (z_i[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}})
                 || (x_i[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}})
                 || (y_i[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});
  assign xy_zero  = (x_i[W-2:0] == '0) || (y_i[W-2:0] == '0);

  always_comb begin
    if (!$isunknown({z_i, x_i, y_i, neg_prod_i, neg_add_i, rnd_mode_i})) begin
      // R10
      excl_chk: assert (special_o != compute_o);
      // R10
      inv_needs_special_chk: assert (!invalid_o || special_o);
      // R10
      compute_clean_chk: assert (!compute_o || (!any_snan && !any_qnan && !any_inf && !xy_zero));
      // R3
      snan_inv_chk: assert (!any_snan || invalid_o);
      // R4
      qnan_no_inv_chk: assert (any_snan || !any_qnan || (!invalid_o && special_o));
    end
  end
endmodule

// File: tb/fma_special_resolver_tb.sv
module fma_special_resolver_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2ns clk = ~clk;

  logic [63:0] z_i, x_i, y_i, result_o;
  logic        neg_prod_i, neg_add_i, special_o, compute_o, invalid_o, prod_sign_o, add_sign_o;
  logic [1:0]  rnd_mode_i;
  logic [2:0]  denorm_o;

  fma_special_resolver u_dut (
    .z_i(z_i), .x_i(x_i), .y_i(y_i),
    .neg_prod_i(neg_prod_i), .neg_add_i(neg_add_i), .rnd_mode_i(rnd_mode_i),
    .special_o(special_o), .compute_o(compute_o), .invalid_o(invalid_o),
    .result_o(result_o), .denorm_o(denorm_o),
    .prod_sign_o(prod_sign_o), .add_sign_o(add_sign_o)
  );

  typedef struct {
    string       req;
    logic        special;
    logic        inv;
    logic [63:0] res;
    logic [2:0]  den;
    logic        psgn;
    logic        asgn;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  logic stim_done = 1'b0;

  localparam logic [63:0] P_ZERO = 64'h0000000000000000;
  localparam logic [63:0] N_ZERO = 64'h8000000000000000;
  localparam logic [63:0] ONE    = 64'h3FF0000000000000;
  localparam logic [63:0] N_ONE  = 64'hBFF0000000000000;
  localparam logic [63:0] TWO    = 64'h4000000000000000;
  localparam logic [63:0] P_INF  = 64'h7FF0000000000000;
  localparam logic [63:0] N_INF  = 64'hFFF0000000000000;
  localparam logic [63:0] DNAN   = 64'h7FF8000000000000;
  localparam logic [63:0] DEN    = 64'h0000000000000001;

  function automatic logic is_den(logic [63:0] v);
    return v[62:52] == 11'd0 && v[51:0] != 52'd0;
  endfunction

  task automatic drive(input logic [63:0] z, input logic [63:0] x, input logic [63:0] y,
                       input logic np, input logic na, input logic [1:0] rm,
                       input logic sp, input logic inv, input logic [63:0] res, input string req);
    exp_t e;
    @(posedge clk);
    z_i = z; x_i = x; y_i = y;
    neg_prod_i = np; neg_add_i = na; rnd_mode_i = rm;
    e.req = req; e.special = sp; e.inv = inv; e.res = res;
    e.den  = {is_den(z), is_den(x), is_den(y)};
    e.psgn = x[63] ^ y[63] ^ np;
    e.asgn = z[63] ^ na;
    exp_q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (special_o !== e.special || compute_o !== !e.special || invalid_o !== e.inv ||
            result_o !== e.res || denorm_o !== e.den || prod_sign_o !== e.psgn ||
            add_sign_o !== e.asgn) begin
          n_errors++;
          $display("FAIL %s: got sp=%b cp=%b inv=%b res=%h den=%b ps=%b as=%b exp sp=%b inv=%b res=%h den=%b ps=%b as=%b",
                   e.req, special_o, compute_o, invalid_o, result_o, denorm_o, prod_sign_o, add_sign_o,
                   e.special, e.inv, e.res, e.den, e.psgn, e.asgn);
        end
      end
    end
  end

  initial begin
    z_i = '0; x_i = '0; y_i = '0;
    neg_prod_i = 1'b0; neg_add_i = 1'b0; rnd_mode_i = 2'd0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: all-zero operands give +0 (R8)
    drive(P_ZERO, P_ZERO, P_ZERO, 0, 0, 2'd0, 1, 0, P_ZERO, "R8 reset");
    // R3 sNaN in x beats qNaN in z
    drive(64'h7FF8000000000123, 64'h7FF0000000000001, ONE, 0, 0, 2'd0, 1, 1, 64'h7FF8000000000001, "R3 x snan");
    // R3 z sNaN wins over x sNaN
    drive(64'h7FF4000000000000, 64'hFFF0000000000005, ONE, 0, 0, 2'd0, 1, 1, 64'h7FFC000000000000, "R3 z snan");
    // R3 y sNaN only
    drive(ONE, TWO, 64'hFFF0000000000009, 0, 0, 2'd0, 1, 1, 64'hFFF8000000000009, "R3 y snan");
    // R4 x qNaN before y qNaN
    drive(ONE, 64'h7FF8000000000055, 64'hFFF8000000000066, 0, 0, 2'd0, 1, 0, 64'h7FF8000000000055, "R4 x qnan");
    // R4 y qNaN, unchanged even with inf*0 present on nothing else
    drive(P_INF, ONE, 64'hFFF8000000000077, 1, 1, 2'd0, 1, 0, 64'hFFF8000000000077, "R4 y qnan");
    // R5 zero * -inf
    drive(ONE, P_ZERO, N_INF, 0, 0, 2'd0, 1, 1, DNAN, "R5 zero*inf");
    // R5 inf * zero with infinite z
    drive(N_INF, P_INF, N_ZERO, 0, 0, 2'd0, 1, 1, DNAN, "R5 inf*zero");
    // R6 +inf product plus -inf
    drive(N_INF, P_INF, TWO, 0, 0, 2'd0, 1, 1, DNAN, "R6 opposite");
    // R6 negated product matches -inf addend
    drive(N_INF, P_INF, TWO, 1, 0, 2'd0, 1, 0, N_INF, "R6 neg_prod");
    // R6 negated addend turns a match into a conflict
    drive(P_INF, P_INF, TWO, 0, 1, 2'd0, 1, 1, DNAN, "R6 neg_add");
    // R6 inf*-inf with finite z
    drive(ONE, P_INF, N_INF, 0, 0, 2'd0, 1, 0, N_INF, "R6 finite z");
    // R7 zero product, -inf addend negated
    drive(N_INF, P_ZERO, TWO, 0, 1, 2'd0, 1, 0, P_INF, "R7 z inf");
    // R7 zero product, finite z negated
    drive(ONE, P_ZERO, TWO, 0, 1, 2'd0, 1, 0, N_ONE, "R7 z finite");
    // R8 +0 product, -0 addend, round-down
    drive(N_ZERO, P_ZERO, TWO, 0, 0, 2'd3, 1, 0, N_ZERO, "R8 rd");
    // R8 same operands, round-to-nearest
    drive(N_ZERO, P_ZERO, TWO, 0, 0, 2'd0, 1, 0, P_ZERO, "R8 rn");
    // R8 equal signs keep the sign
    drive(N_ZERO, N_ZERO, TWO, 0, 0, 2'd0, 1, 0, N_ZERO, "R8 equal");
    // R9 finite product, +inf addend, denormal y (R1)
    drive(P_INF, ONE, DEN, 0, 0, 2'd0, 1, 0, P_INF, "R9 z inf");
    // R9 negated addend
    drive(P_INF, N_ONE, TWO, 0, 1, 2'd0, 1, 0, N_INF, "R9 neg_add");
    // R10 plain normals
    drive(ONE, ONE, TWO, 0, 0, 2'd0, 0, 0, P_ZERO, "R10 compute");
    // R1 R2 denormals with negate product
    drive(DEN, DEN, N_ONE, 1, 0, 2'd1, 0, 0, P_ZERO, "R1 R2 denorm");
    // R2 negate addend
    drive(ONE, N_ONE, ONE, 0, 1, 2'd2, 0, 0, P_ZERO, "R2 signs");
    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk);
    stim_done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!stim_done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!stim_done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout exp completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule